// File: doc/BRIEF.md
# Port Interrupt Status and Enable Hub

This block collects event pulses for a group of storage-link ports and turns them into interrupt lines. Each port owns twelve event sources. A one-cycle pulse on a source latches a raw status bit, which stays set until software clears it by writing a one to it. A per-port enable mask gates the raw bits into a masked view, and the OR of the masked view drives that port's interrupt line. The host line is the OR of all the port lines.

Software reaches the block through a plain register port. A write picks a port and one of three targets: the status word (write-one-to-clear), the enable-set word, or the enable-clear word. With separate set and clear targets, software can change single enable bits without a read-modify-write. Both enable targets also hold a 2-bit steering field that software sets and clears the same way. A read is combinational. It picks a port and one of four views: the status word, the enable word, a slot word carrying an error attention flag, and the host summary of the port lines. There is no streamed data here, so every pin is a plain control or status pin.

Top module: `lih_irq_top`

## Requirements
- R1: After reset every enable mask, every steering field and every raw status bit is zero. `port_irq` and `host_irq` are low.
- R2: A pulse on event `i` of port `p` (`evt_in[p*NEVT+i]`) sets raw bit `i` of that port at the next clock edge. The bit stays set until it is cleared.
- R3: A status read (`rd_sel`=0) returns raw bits in 27:16 and raw AND enable in 11:0. Bits 15:12 and 31:28 read zero.
- R4: A write with `wr_sel`=1 ORs `wr_data[11:0]` into the enable mask. A write with `wr_sel`=2 clears the mask bits where `wr_data[11:0]` holds ones. Zero bits leave the mask unchanged. An enable read (`rd_sel`=1) returns the mask in bits 11:0 and the steering field in bits 31:30.
- R5: The steering field follows the same rule from `wr_data[31:30]`: `wr_sel`=1 sets the bits that are one and `wr_sel`=2 clears them.
- R6: A status write (`wr_sel`=0) clears raw bit `i` when `wr_data[i]` or `wr_data[16+i]` is one. Writing 0x0fff0fff clears every raw bit.
- R7: When an event pulse and a clear of the same bit arrive in the same cycle, the bit stays set.
- R8: `port_irq[p]` is high exactly when some raw bit of port `p` is set while its enable bit is set. `host_irq` is the OR of all `port_irq` bits. A host read (`rd_sel`=3) returns `port_irq` in bits NPORTS-1:0 and zero elsewhere.
- R9: A slot read (`rd_sel`=2) returns raw bit 1 (command error) of the port in bit 31. All other bits read zero.
- R10: A write reaches only the port named by `wr_port`. A write with `wr_sel`=3 changes nothing.
- R11: An event on one port leaves every other port's status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_port | input | PW | Port addressed by the write |
| wr_sel | input | 2 | Write target: 0 status clear, 1 enable set, 2 enable clear, 3 none |
| wr_data | input | 32 | Write data |
| rd_port | input | PW | Port addressed by the read |
| rd_sel | input | 2 | Read view: 0 status, 1 enable, 2 slot, 3 host summary |
| rd_data | output | 32 | Read data (combinational) |
| evt_in | input | NPORTS*NEVT | Single-cycle event pulses, port-major |
| port_irq | output | NPORTS | Per-port interrupt lines |
| host_irq | output | 1 | OR of all port lines |

## Verification
The assertions check four things on every cycle, for every raw bit: an event latches its bit, a clear without a competing event drops it, the bit holds when neither arrives, and an event wins over a clear in the same cycle. They also check that clearing the whole enable mask of a port drops that port's line at once. The read views can only be shown by the bench scenarios: the bit layout of the status, enable, slot and host words, steering updates, isolation between ports, and the ignored write target. The bench checks these by comparing every view against a model under random traffic, plus a few directed cases.

// File: rtl/lih_pkg.sv
package lih_pkg;
  localparam int REG_W     = 32;
  localparam int RAW_LSB   = 16;
  localparam int STEER_LSB = 30;
  localparam int STEER_W   = 2;
  localparam int ERR_BIT   = 1;
  localparam int ATTN_BIT  = 31;

  typedef enum logic [1:0] {
    WR_STAT_CLR = 2'd0,
    WR_EN_SET   = 2'd1,
    WR_EN_CLR   = 2'd2,
    WR_NONE     = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    RD_STAT = 2'd0,
    RD_ENAB = 2'd1,
    RD_SLOT = 2'd2,
    RD_HOST = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/lih_port.sv
module lih_port
  import lih_pkg::*;
#(
  parameter int NEVT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NEVT-1:0]    evt,
  input  logic [NEVT-1:0]    clr_mask,
  input  logic               en_set_we,
  input  logic               en_clr_we,
  input  logic [NEVT-1:0]    en_bits,
  input  logic [STEER_W-1:0] steer_bits,
  output logic [NEVT-1:0]    raw_q,
  output logic [NEVT-1:0]    en_q,
  output logic [STEER_W-1:0] steer_q,
  output logic               irq
);
  // Events have priority over clears, so OR them in after masking.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= '0;
      en_q    <= '0;
      steer_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_mask) | evt;
      if (en_set_we) begin
        en_q    <= en_q | en_bits;
        steer_q <= steer_q | steer_bits;
      end else if (en_clr_we) begin
        en_q    <= en_q & ~en_bits;
        steer_q <= steer_q & ~steer_bits;
      end
    end
  end

  assign irq = |(raw_q & en_q);
endmodule

// File: rtl/lih_rdmux.sv
module lih_rdmux
  import lih_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int NEVT   = 12,
  parameter int PW     = 2
) (
  input  logic [NPORTS*NEVT-1:0]    raw_all,
  input  logic [NPORTS*NEVT-1:0]    en_all,
  input  logic [NPORTS*STEER_W-1:0] steer_all,
  input  logic [NPORTS-1:0]         irq_all,
  input  logic [PW-1:0]             rd_port,
  input  logic [1:0]                rd_sel,
  output logic [REG_W-1:0]          rd_data
);
  logic [NEVT-1:0]    raw_s, en_s;
  logic [STEER_W-1:0] steer_s;
  logic               port_ok;

  always_comb begin
    raw_s   = '0;
    en_s    = '0;
    steer_s = '0;
    port_ok = (int'(rd_port) < NPORTS);
    if (port_ok) begin
      raw_s   = raw_all[rd_port*NEVT +: NEVT];
      en_s    = en_all[rd_port*NEVT +: NEVT];
      steer_s = steer_all[rd_port*STEER_W +: STEER_W];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel_e'(rd_sel))
      RD_STAT: begin
        rd_data[NEVT-1:0]         = raw_s & en_s;
        rd_data[RAW_LSB +: NEVT]  = raw_s;
      end
      RD_ENAB: begin
        rd_data[NEVT-1:0]             = en_s;
        rd_data[STEER_LSB +: STEER_W] = steer_s;
      end
      RD_SLOT: rd_data[ATTN_BIT] = raw_s[ERR_BIT];
      RD_HOST: rd_data[NPORTS-1:0] = irq_all;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/lih_irq_top.sv
module lih_irq_top
  import lih_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int NEVT   = 12,
  parameter int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PW-1:0]          wr_port,
  input  logic [1:0]             wr_sel,
  input  logic [31:0]            wr_data,
  input  logic [PW-1:0]          rd_port,
  input  logic [1:0]             rd_sel,
  output logic [31:0]            rd_data,
  input  logic [NPORTS*NEVT-1:0] evt_in,
  output logic [NPORTS-1:0]      port_irq,
  output logic                   host_irq
);
  logic [NPORTS*NEVT-1:0]    raw_all, en_all;
  logic [NPORTS*STEER_W-1:0] steer_all;
  logic [NEVT-1:0]           wr_clr_bits;
  logic                      unused_wr;

  assign wr_clr_bits = wr_data[NEVT-1:0] | wr_data[RAW_LSB +: NEVT];
  assign unused_wr   = ^wr_data;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_en && (wr_port == PW'(p));

    lih_port #(.NEVT(NEVT)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt_in[p*NEVT +: NEVT]),
      .clr_mask   ((hit && wr_sel_e'(wr_sel) == WR_STAT_CLR) ? wr_clr_bits : '0),
      .en_set_we  (hit && wr_sel_e'(wr_sel) == WR_EN_SET),
      .en_clr_we  (hit && wr_sel_e'(wr_sel) == WR_EN_CLR),
      .en_bits    (wr_data[NEVT-1:0]),
      .steer_bits (wr_data[STEER_LSB +: STEER_W]),
      .raw_q      (raw_all[p*NEVT +: NEVT]),
      .en_q       (en_all[p*NEVT +: NEVT]),
      .steer_q    (steer_all[p*STEER_W +: STEER_W]),
      .irq        (port_irq[p])
    );
  end

  assign host_irq = |port_irq;

  lih_rdmux #(.NPORTS(NPORTS), .NEVT(NEVT), .PW(PW)) u_rd (
    .raw_all   (raw_all),
    .en_all    (en_all),
    .steer_all (steer_all),
    .irq_all   (port_irq),
    .rd_port   (rd_port),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/lih_irq_chk.sv
module lih_irq_chk #(
  parameter int NPORTS = 4,
  parameter int NEVT   = 12,
  parameter int PW     = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [PW-1:0]          wr_port,
  input logic [1:0]             wr_sel,
  input logic [31:0]            wr_data,
  input logic [NPORTS*NEVT-1:0] evt_in,
  input logic [NPORTS*NEVT-1:0] raw_all,
  input logic [NPORTS-1:0]      port_irq
);
  for (genvar k = 0; k < NPORTS*NEVT; k++) begin : g_bit
    localparam int P = k / NEVT;
    localparam int I = k % NEVT;
    logic clr_k;
    assign clr_k = wr_en && wr_sel == 2'd0 && wr_port == PW'(P) &&
                   (wr_data[I] || wr_data[16+I]);

    p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_in[k] |=> raw_all[k]);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_in[k] && !clr_k) |=> $stable(raw_all[k]));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_k && !evt_in[k]) |=> !raw_all[k]);
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_k && evt_in[k]) |=> raw_all[k]);
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_pt
    p_mask_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && wr_port == PW'(p) && (&wr_data[NEVT-1:0]))
      |=> !port_irq[p]);
  end
endmodule

bind lih_irq_top lih_irq_chk #(.NPORTS(NPORTS), .NEVT(NEVT), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_port  (wr_port),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .evt_in   (evt_in),
  .raw_all  (raw_all),
  .port_irq (port_irq)
);

// File: tb/sim_lih_irq_top.sv
`timescale 1ns/1ps
module sim_lih_irq_top;
  localparam int NP = 4;
  localparam int NE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [1:0]    wr_port = '0, wr_sel = '0, rd_port = '0, rd_sel = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NP*NE-1:0] evt_in = '0;
  logic [NP-1:0] port_irq;
  logic          host_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NE-1:0] m_raw [NP];
  logic [NE-1:0] m_en  [NP];
  logic [1:0]    m_st  [NP];

  lih_irq_top #(.NPORTS(NP), .NEVT(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_port(rd_port), .rd_sel(rd_sel),
    .rd_data(rd_data), .evt_in(evt_in), .port_irq(port_irq), .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] m_irq();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = |(m_raw[p] & m_en[p]);
    return v;
  endfunction

  function automatic logic [31:0] m_read(input int p, input int sel);
    logic [31:0] d = '0;
    case (sel)
      0: begin d[11:0] = m_raw[p] & m_en[p]; d[27:16] = m_raw[p]; end
      1: begin d[11:0] = m_en[p]; d[31:30] = m_st[p]; end
      2: d[31] = m_raw[p][1];
      default: d[NP-1:0] = m_irq();
    endcase
    return d;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_raw[p] = '0; m_en[p] = '0; m_st[p] = '0;
    end
  endtask

  task automatic model_step();
    for (int p = 0; p < NP; p++) begin
      logic [NE-1:0] clr = '0;
      if (wr_en && wr_port == p[1:0] && wr_sel == 2'd0) clr = wr_data[11:0] | wr_data[27:16];
      m_raw[p] = (m_raw[p] & ~clr) | evt_in[p*NE +: NE];
      if (wr_en && wr_port == p[1:0] && wr_sel == 2'd1) begin
        m_en[p] = m_en[p] | wr_data[11:0]; m_st[p] = m_st[p] | wr_data[31:30];
      end else if (wr_en && wr_port == p[1:0] && wr_sel == 2'd2) begin
        m_en[p] = m_en[p] & ~wr_data[11:0]; m_st[p] = m_st[p] & ~wr_data[31:30];
      end
    end
  endtask

  // Inputs were set after a falling edge; clock them in and return at the next falling edge.
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 1'b0; evt_in = '0; wr_data = '0; wr_sel = '0; wr_port = '0;
  endtask

  task automatic check_all(input string tag);
    string sn [4] = '{"R3 status", "R4 enable", "R9 slot", "R8 host"};
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < 4; s++) begin
        rd_port = p[1:0]; rd_sel = s[1:0];
        #1;
        chk($sformatf("%s %s port %0d", tag, sn[s], p), rd_data, m_read(p, s));
      end
    chk({tag, " R8 port_irq"}, {28'b0, port_irq}, {28'b0, m_irq()});
    chk({tag, " R8 host_irq"}, {31'b0, host_irq}, {31'b0, |m_irq()});
  endtask

  task automatic wr(input int p, input int sel, input logic [31:0] d);
    wr_en = 1'b1; wr_port = p[1:0]; wr_sel = sel[1:0]; wr_data = d;
  endtask

  initial begin
    #(8*200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // R2: single event latches and holds
    evt_in[0] = 1'b1; step(); check_all("R2 latch");
    step(); check_all("R2 hold");

    // R7: event and clear of the same bit in one cycle
    wr(1, 1, 32'h0000_0fff); step();
    evt_in[1*NE+5] = 1'b1; wr(1, 0, 32'h0000_0020); step(); check_all("R7 event wins");
    wr(1, 0, 32'h0020_0000); step(); check_all("R7 later clear");

    // R5: steering set and clear
    wr(3, 1, 32'hC000_0000); step(); check_all("R5 steer set");
    wr(3, 2, 32'h4000_0000); step(); check_all("R5 steer clear");

    // R11: event on port 2 only
    evt_in[2*NE +: NE] = 12'h802; step(); check_all("R11 isolation");

    // R10: ignored target and other port untouched
    wr(2, 3, 32'hffff_ffff); step(); check_all("R10 ignored");
    wr(0, 1, 32'h0000_0fff); step(); check_all("R10 one port");

    // R6: full clear on every port
    evt_in = '1; step(); check_all("R6 all set");
    for (int p = 0; p < NP; p++) begin
      wr(p, 0, 32'h0fff_0fff); step();
    end
    check_all("R6 full clear");

    // R4: clear whole mask drops the line
    evt_in = '1; step();
    wr(0, 2, 32'h0000_0fff); step(); check_all("R4 mask off");

    for (int n = 0; n < 3000; n++) begin
      evt_in = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom_range(1, 0) == 1) begin
        logic [31:0] d = $urandom;
        if ($urandom_range(7, 0) == 0) d = 32'h0fff_0fff;
        wr($urandom_range(3, 0), $urandom_range(3, 0), d);
      end
      step();
      check_all("R2 R6 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule